// File: doc/BRIEF.md
# Prescaled Timer Counter

This block is a 16-bit up-counter whose count rate comes from a small prescaler. Software controls it through one 8-bit control register on a plain write-strobe bus, and the register contents are always visible on a read-data port. The register holds a halt flag, a self-clearing clear strobe and a 3-bit rate select. Rate codes 0 to 6 advance the counter once every 1, 2, 4, ..., 64 bus clocks. Code 7 advances it on each rising edge of an external pin, which is first synchronized into the bus clock domain.

Every path runs on the single bus clock, and the prescaler only produces one-cycle enables. When the counter wraps from its top value it raises a one-cycle overflow pulse. A capture-gate output follows the halt flag, so a neighbouring input-capture unit is blocked while the counter is halted. Both the halt flag and the new rate take effect from the clock edge that follows the write.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the register reads 0x20 (halt flag in bit 5 set, rate select in bits 2:0 equal to 000). The count is 0, the overflow pulse is low and the capture gate is low.
- R2: While the halt flag (bit 5) is 1, the count holds its value. A write that sets the flag stops counting from the next clock edge onward.
- R3: When the halt flag is cleared, counting resumes from the held value, with no jump and no reload.
- R4: The capture-gate output is high exactly when the halt flag reads 0.
- R5: A write with bit 4 set clears the count and the prescaler phase to zero at that write's clock edge. Counting then restarts from 0x0000 with a full prescale period before the first step. Bits 5 and 2:0 of that write are stored as in any other write.
- R6: Bit 4 always reads back as 0.
- R7: A single write with bits 5 and 4 both set leaves the count held at 0x0000.
- R8: Rate code k in the range 0 to 6 makes the count equal floor(N / 2^k) N clock edges after a clearing write.
- R9: Rate code 7 counts each rising edge of the external pin once. The increment appears at the third bus clock edge after the pin is first sampled high. The pin must stay high for at least two bus clocks and low for at least two bus clocks.
- R10: The count wraps from 0xFFFF to 0x0000, and the overflow output is high for exactly the one cycle in which the count reads 0x0000 after the wrap.
- R11: Register bits 7, 6 and 3 read as 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| ext_clk_in | input | 1 | External count source, asynchronous |
| count | output | 16 | Current counter value |
| ovf_pulse | output | 1 | One-cycle pulse on wrap to zero |
| capture_en | output | 1 | Input-capture gate, low while halted |

## Verification
The clear strobe and a count enable can land on the same clock edge, and so can the clear strobe and the halt flag. These collisions are provoked by writing the clear bit while the counter runs at divide-by-1, where an enable fires on every edge, and by writing halt and clear together. The result is judged by the count reading exactly zero after that edge and staying at zero while halted. A clear issued in the middle of a divide-by-4 period is judged by the first step arriving a full four edges later, which shows the prescaler phase was reset along with the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CTRL_W   = 8;
   localparam int HALT_BIT = 5;
   localparam int CLR_BIT  = 4;
   localparam int SEL_LSB  = 0;
   localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
   import tmr_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] rdata,
   output logic              halt,
   output logic [SEL_W-1:0]  sel,
   output logic              clr_pulse
);
   localparam int SEL_MSB = SEL_LSB + SEL_W - 1;

   if (SEL_MSB >= CLR_BIT) begin : g_bad_sel
      $error("rate select field overlaps the clear bit");
   end

   logic             halt_q;
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= CTRL_RESET[HALT_BIT];
         sel_q  <= CTRL_RESET[SEL_MSB:SEL_LSB];
      end else if (wr) begin
         halt_q <= wdata[HALT_BIT];
         sel_q  <= wdata[SEL_MSB:SEL_LSB];
      end
   end

   // the clear strobe is never stored, so it always reads back as zero
   assign clr_pulse = wr & wdata[CLR_BIT];

   always_comb begin
      rdata                   = '0;
      rdata[HALT_BIT]         = halt_q;
      rdata[SEL_MSB:SEL_LSB]  = sel_q;
   end

   assign halt = halt_q;
   assign sel  = sel_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int DIV_STAGES  = 7,
   parameter int SEL_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   input  logic             ext_clk,
   output logic             count_en
);
   localparam int DIV_W  = DIV_STAGES - 1;
   localparam int N_SRC  = 1 << SEL_W;

   if (DIV_STAGES < 2) begin : g_bad_div
      $error("DIV_STAGES must be at least 2");
   end
   if (DIV_STAGES + 1 > N_SRC) begin : g_bad_selw
      $error("SEL_W too narrow for the divider codes plus the external code");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   // free-running phase divider, paused while halted
   logic [DIV_W-1:0] div_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (clr)    div_q <= '0;
      else if (run)    div_q <= div_q + 1'b1;
   end

   // external pin synchronizer plus one history flop for the edge
   logic [SYNC_STAGES:0] sync_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
   end
   logic ext_edge;
   assign ext_edge = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

   // one tick source per select code
   logic [N_SRC-1:0] tick;
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (i == 0) begin : g_div1
         assign tick[i] = 1'b1;
      end else if (i < DIV_STAGES) begin : g_divn
         assign tick[i] = &div_q[i-1:0];
      end else begin : g_ext
         assign tick[i] = ext_edge;
      end
   end

   assign count_en = run & ~clr & tick[sel];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             count_en,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] TOP = '1;

   if (CNT_W < 2) begin : g_bad_w
      $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= count_en & (cnt_q == TOP) & ~clr;
         if (clr)           cnt_q <= '0;
         else if (count_en) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count = cnt_q;
   assign ovf   = ovf_q;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DIV_STAGES  = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [CTRL_W-1:0] reg_rdata,
   input  logic              ext_clk_in,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_pulse,
   output logic              capture_en
);
   localparam int SEL_W = $clog2(DIV_STAGES + 1);

   logic             halt;
   logic [SEL_W-1:0] sel;
   logic             clr;
   logic             count_en;

   tmr_ctrl_reg #(.SEL_W(SEL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .rdata(reg_rdata), .halt(halt), .sel(sel), .clr_pulse(clr)
   );

   tmr_prescaler #(
      .DIV_STAGES(DIV_STAGES), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .run(~halt), .clr(clr), .sel(sel),
      .ext_clk(ext_clk_in), .count_en(count_en)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .count_en(count_en),
      .count(count), .ovf(ovf_pulse)
   );

   assign capture_en = ~halt;
endmodule

// File: rtl/prescaled_timer_chk.sv
module prescaled_timer_chk
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [CTRL_W-1:0] reg_wdata,
   input logic [CTRL_W-1:0] reg_rdata,
   input logic [CNT_W-1:0]  count,
   input logic              ovf_pulse,
   input logic              capture_en
);
   // R4
   cap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture_en == ~reg_rdata[HALT_BIT]);

   // R2
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[HALT_BIT] && !reg_wr) |=> $stable(count));

   // R5
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_wdata[CLR_BIT]) |=> (count == '0));

   // R7
   halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[HALT_BIT] && !reg_wr && count == '0) |=> (count == '0));

   // R6
   clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[CLR_BIT] == 1'b0);

   // R11
   spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[7:6] == 2'b00) && (reg_rdata[3] == 1'b0));

   // R10
   ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (count == '0));

   // R10
   ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> !ovf_pulse);
endmodule

bind prescaled_timer prescaled_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .count(count), .ovf_pulse(ovf_pulse),
   .capture_en(capture_en)
);

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        ext_clk_in = 1'b0;
   logic [15:0] count;
   logic        ovf_pulse;
   logic        capture_en;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   prescaled_timer i_prescaled_timer (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ext_clk_in(ext_clk_in), .count(count),
      .ovf_pulse(ovf_pulse), .capture_en(capture_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      reg_wdata = 8'h00;
   endtask

   task automatic t_reset_state;
      check("R1 rdata", reg_rdata, 32'h20);
      check("R1 count", count, 0);
      check("R1 ovf", ovf_pulse, 0);
      check("R1 capture_en", capture_en, 0);
      idle(10);
      check("R1 R2 count held after reset", count, 0);
   endtask

   task automatic t_rates;
      for (int k = 0; k < 7; k++) begin
         wr(8'h10 | 8'(k));
         check("R8 sel readback", reg_rdata, 32'(k));
         check("R4 capture_en running", capture_en, 1);
         idle(37);
         check($sformatf("R8 div code %0d", k), count, 32'(37 >> k));
      end
   endtask

   task automatic t_halt_resume;
      logic [15:0] held;
      wr(8'h10);
      idle(5);
      wr(8'h20);
      held = count;
      check("R4 capture_en halted", capture_en, 0);
      idle(6);
      check("R2 count held", count, held);
      wr(8'h00);
      check("R3 no step at release edge", count, held);
      idle(3);
      check("R3 resume from held", count, held + 16'd3);
   endtask

   task automatic t_clear_prescaler;
      wr(8'h12);
      idle(6);
      wr(8'h12);
      check("R5 cleared", count, 0);
      check("R5 sel kept", reg_rdata, 32'h02);
      idle(3);
      check("R5 no early step", count, 0);
      idle(1);
      check("R5 first step after full period", count, 1);
   endtask

   task automatic t_halt_and_clear;
      wr(8'h10);
      idle(9);
      wr(8'h30);
      check("R7 zero", count, 0);
      idle(8);
      check("R7 held at zero", count, 0);
      check("R7 readback", reg_rdata, 32'h20);
   endtask

   task automatic t_readback;
      wr(8'h37);
      check("R6 clear bit reads 0", reg_rdata, 32'h27);
      wr(8'hFF);
      check("R11 spare bits read 0", reg_rdata, 32'h27);
   endtask

   task automatic t_overflow;
      wr(8'h10);
      idle(65535);
      check("R10 top value", count, 32'hFFFF);
      check("R10 no early ovf", ovf_pulse, 0);
      idle(1);
      check("R10 wrapped", count, 0);
      check("R10 ovf pulse", ovf_pulse, 1);
      idle(1);
      check("R10 ovf one cycle", ovf_pulse, 0);
      check("R10 counting on", count, 1);
   endtask

   task automatic t_external;
      wr(8'h17);
      idle(4);
      check("R9 idle pin no count", count, 0);
      @(negedge clk);
      ext_clk_in = 1'b1;
      idle(2);
      check("R9 latency not yet", count, 0);
      idle(1);
      check("R9 third edge step", count, 1);
      idle(2);
      ext_clk_in = 1'b0;
      idle(4);
      for (int p = 0; p < 3; p++) begin
         ext_clk_in = 1'b1;
         idle(4);
         ext_clk_in = 1'b0;
         idle(4);
      end
      check("R9 one step per rise", count, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_rates();
      t_halt_resume();
      t_clear_prescaler();
      t_halt_and_clear();
      t_readback();
      t_external();
      t_overflow();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule